// File: doc/BRIEF.md
# Atomic Memory Operation Controller

This block sits between a core's load/store port and a simple doubleword-addressed memory. It carries out three kinds of request. A load-reserved reads a location and arms a reservation on it. A store-conditional writes only when that reservation is still intact. An atomic read-modify-write fetches the old value, combines it with a source operand and writes the combined value back, and no other request can come between the read and the write. The controller keeps a single reservation, made of an address and a valid flag. A snoop port reports writes made by other agents, and such a write breaks the reservation when it hits the reserved address.

Each request selects doubleword (64-bit) or word (32-bit) width. A word operation works on the low 32-bit lane of the addressed doubleword and leaves the upper lane untouched. The ordering bits on the request (acquire and release) are not acted on. They are returned beside the response, together with a flag raised when both are set.

The core drives one request per cycle while `busy` is low. The controller answers with a single-cycle `rsp_done` pulse, and `rsp_data` is valid in that same cycle. The attached memory returns read data one clock after it samples `mem_rd`. It applies `mem_wr` at the clock edge where it samples it, writing only the lanes enabled in `mem_wmask`.

Top module: `amo_ctrl`

## Requirements
- R1: While reset is high and right after it is released, `rsp_done`, `busy`, `mem_rd`, `mem_wr` and `mem_lock` are all 0.
- R2: Operation code 0 (load-reserved) reads the addressed doubleword. It returns the whole doubleword in doubleword mode, or the low 32 bits sign-extended to 64 in word mode. `rsp_done` rises on the third clock edge, counting the accepting edge as the first.
- R3: Operation code 1 (store-conditional) succeeds when a reservation is valid for the same address. It then writes the source: all 64 bits in doubleword mode, or only the low lane in word mode with the upper lane unchanged. It returns 0, with `rsp_done` on the second edge.
- R4: A store-conditional with no valid reservation, or with a reservation on another address, writes nothing. It returns 1, with `rsp_done` on the accepting edge itself.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails. A second store-conditional to the same address therefore fails.
- R6: A snooped write (`snoop_valid`) whose address equals the reserved address clears the reservation. A snooped write to any other address leaves it intact.
- R7: Operation codes 2..10 are atomic read-modify-writes. They return the old value and store f(old, src), where 2=swap, 3=add, 4=xor, 5=and, 6=or, 7=signed min, 8=signed max, 9=unsigned min and 10=unsigned max. `rsp_done` rises on the fourth edge.
- R8: A word-mode atomic computes on the low 32 bits only, with 32-bit signed or unsigned comparisons and add wrapping at 32 bits. It keeps the upper lane in memory and returns the old low word sign-extended.
- R9: During an atomic operation, `mem_lock` and `busy` are high from the cycle after the accepting edge through the write cycle. Requests presented while `busy` is high are ignored.
- R10: With `rsp_done`, the controller presents `rsp_aq` and `rsp_rl` equal to the request's acquire and release bits, and `rsp_seqcst` high exactly when both were set.
- R11: `mem_rd` is a single-cycle pulse and is never high together with `mem_wr`. Every `mem_wr` cycle is followed by `rsp_done` in the next cycle.
- R12: Operation codes 11..15 make no memory access and return 0, with `rsp_done` on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Doubleword address |
| req_data | input | XLEN | Source operand |
| req_dw | input | 1 | 1 = doubleword, 0 = word |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| busy | output | 1 | An operation is in progress |
| rsp_done | output | 1 | Response valid pulse |
| rsp_data | output | XLEN | Response value |
| rsp_aq | output | 1 | Acquire bit of the finished request |
| rsp_rl | output | 1 | Release bit of the finished request |
| rsp_seqcst | output | 1 | Both ordering bits were set |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_lock | output | 1 | Memory held across read-modify-write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | XLEN | Memory write data |
| mem_wmask | output | 2 | Lane enables (bit0 low word, bit1 high word) |
| mem_rdata | input | XLEN | Memory read data, one cycle after mem_rd |
| snoop_valid | input | 1 | Another agent writes memory |
| snoop_addr | input | AW | Address of that write |

## Verification
A wrong reservation flag or address shows up at the ports within the next store-conditional. That request either returns the wrong 0/1 code, with its latency jumping between one and two edges, or it writes memory when it should not. A bad sequencing state shows as a done pulse on the wrong edge, a lock that outlives the write, or a stray read strobe, all within one operation. Errors in the combining logic or in the lane merge appear in the memory word written at the end of that same atomic operation, and again in the value a later read returns.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    OP_LR   = 4'd0,
    OP_SC   = 4'd1,
    OP_SWAP = 4'd2,
    OP_ADD  = 4'd3,
    OP_XOR  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_MIN  = 4'd7,
    OP_MAX  = 4'd8,
    OP_MINU = 4'd9,
    OP_MAXU = 4'd10
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CAP  = 2'd2,
    ST_WR   = 2'd3
  } amo_st_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_op_e          op,
  input  logic             dw,
  input  logic [XLEN-1:0]  old_val,
  input  logic [XLEN-1:0]  src_val,
  output logic [XLEN-1:0]  new_val
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a, b, r;

  // Word operands are sign-extended, which keeps both signed and unsigned order.
  assign a = dw ? old_val : {{HALF{old_val[HALF-1]}}, old_val[HALF-1:0]};
  assign b = dw ? src_val : {{HALF{src_val[HALF-1]}}, src_val[HALF-1:0]};

  always_comb begin
    case (op)
      OP_ADD:  r = a + b;
      OP_XOR:  r = a ^ b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_MIN:  r = ($signed(a) < $signed(b)) ? a : b;
      OP_MAX:  r = ($signed(a) < $signed(b)) ? b : a;
      OP_MINU: r = (a < b) ? a : b;
      OP_MAXU: r = (a < b) ? b : a;
      default: r = b;
    endcase
  end

  assign new_val = dw ? r : {old_val[XLEN-1:HALF], r[HALF-1:0]};
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic          clr_en,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  input  logic [AW-1:0] chk_addr,
  output logic          hit
);
  logic          rv_q;
  logic [AW-1:0] ra_q;
  logic          snoop_hit;

  assign snoop_hit = snoop_valid && rv_q && (snoop_addr == ra_q);
  assign hit       = rv_q && (ra_q == chk_addr) && !snoop_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0;
      ra_q <= '0;
    end else if (set_en) begin
      rv_q <= 1'b1;
      ra_q <= set_addr;
    end else if (clr_en || snoop_hit) begin
      rv_q <= 1'b0;
    end
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
#(
  parameter int AW   = 8,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [3:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [XLEN-1:0] req_data,
  input  logic            req_dw,
  input  logic            req_aq,
  input  logic            req_rl,
  output logic            busy,
  output logic            rsp_done,
  output logic [XLEN-1:0] rsp_data,
  output logic            rsp_aq,
  output logic            rsp_rl,
  output logic            rsp_seqcst,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_lock,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [1:0]      mem_wmask,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            snoop_valid,
  input  logic [AW-1:0]   snoop_addr
);
  localparam int HALF = XLEN / 2;

  amo_st_e         st_q;
  amo_op_e         op_q, op_in;
  logic            dw_q;
  logic [XLEN-1:0] src_q, old_q, rd_ext, alu_res;
  logic            accept, sc_ok;

  assign op_in  = amo_op_e'(req_op);
  assign accept = req_valid && (st_q == ST_IDLE);
  assign busy   = (st_q != ST_IDLE);
  assign rd_ext = dw_q ? mem_rdata : {{HALF{mem_rdata[HALF-1]}}, mem_rdata[HALF-1:0]};

  amo_resv #(.AW(AW)) u_resv (
    .clk        (clk),
    .rst        (rst),
    .set_en     (accept && (op_in == OP_LR)),
    .set_addr   (req_addr),
    .clr_en     (accept && (op_in == OP_SC)),
    .snoop_valid(snoop_valid),
    .snoop_addr (snoop_addr),
    .chk_addr   (req_addr),
    .hit        (sc_ok)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op     (op_q),
    .dw     (dw_q),
    .old_val(mem_rdata),
    .src_val(src_q),
    .new_val(alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_LR;
      dw_q       <= 1'b0;
      src_q      <= '0;
      old_q      <= '0;
      rsp_done   <= 1'b0;
      rsp_data   <= '0;
      rsp_aq     <= 1'b0;
      rsp_rl     <= 1'b0;
      rsp_seqcst <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_lock   <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_wmask  <= 2'b00;
    end else begin
      rsp_done <= 1'b0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q       <= op_in;
            dw_q       <= req_dw;
            src_q      <= req_data;
            mem_addr   <= req_addr;
            mem_wmask  <= req_dw ? 2'b11 : 2'b01;
            rsp_aq     <= req_aq;
            rsp_rl     <= req_rl;
            rsp_seqcst <= req_aq && req_rl;
            case (op_in)
              OP_LR: begin
                mem_rd <= 1'b1;
                st_q   <= ST_RD;
              end
              OP_SC: begin
                if (sc_ok) begin
                  mem_wr    <= 1'b1;
                  mem_wdata <= req_dw ? req_data : {{HALF{1'b0}}, req_data[HALF-1:0]};
                  st_q      <= ST_WR;
                end else begin
                  rsp_data <= {{(XLEN-1){1'b0}}, 1'b1};
                  rsp_done <= 1'b1;
                end
              end
              OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
              OP_MIN, OP_MAX, OP_MINU, OP_MAXU: begin
                mem_rd   <= 1'b1;
                mem_lock <= 1'b1;
                st_q     <= ST_RD;
              end
              default: begin
                rsp_data <= '0;
                rsp_done <= 1'b1;
              end
            endcase
          end
        end
        ST_RD: st_q <= ST_CAP;
        ST_CAP: begin
          if (op_q == OP_LR) begin
            rsp_data <= rd_ext;
            rsp_done <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            old_q     <= rd_ext;
            mem_wdata <= alu_res;
            mem_wr    <= 1'b1;
            st_q      <= ST_WR;
          end
        end
        default: begin
          rsp_done <= 1'b1;
          mem_lock <= 1'b0;
          rsp_data <= (op_q == OP_SC) ? '0 : old_q;
          st_q     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/amo_ctrl_chk.sv
module amo_ctrl_chk #(
  parameter int AW   = 8,
  parameter int XLEN = 64
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic rsp_done,
  input logic mem_rd,
  input logic mem_wr,
  input logic mem_lock
);
  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_rd |=> !mem_rd);
  // R11
  wr_done_chk: assert property (@(posedge clk) disable iff (rst) mem_wr |=> rsp_done);
  // R9
  lock_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_lock |-> busy);
  // R9
  lock_release_chk: assert property (@(posedge clk) disable iff (rst) (mem_wr && mem_lock) |=> !mem_lock);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) rsp_done |-> !busy);
endmodule

bind amo_ctrl amo_ctrl_chk #(.AW(AW), .XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .rsp_done(rsp_done),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .mem_lock(mem_lock)
);

// File: tb/amo_ctrl_tb.sv
module amo_ctrl_tb;
  localparam int AW = 8;
  localparam int XLEN = 64;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [XLEN-1:0] req_data = '0;
  logic req_dw = 1'b0, req_aq = 1'b0, req_rl = 1'b0;
  logic busy, rsp_done, rsp_aq, rsp_rl, rsp_seqcst;
  logic [XLEN-1:0] rsp_data;
  logic mem_rd, mem_wr, mem_lock;
  logic [AW-1:0] mem_addr;
  logic [XLEN-1:0] mem_wdata;
  logic [1:0] mem_wmask;
  logic [XLEN-1:0] mem_rdata = '0;
  logic snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  amo_ctrl #(.AW(AW), .XLEN(XLEN)) u_dut (.*);

  // bench-side memory
  logic [63:0] mem [DEPTH];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) begin
      if (mem_wmask[0]) mem[mem_addr][31:0]  <= mem_wdata[31:0];
      if (mem_wmask[1]) mem[mem_addr][63:32] <= mem_wdata[63:32];
    end
  end

  // reference model
  logic [63:0] ref_mem [DEPTH];
  logic ref_rv = 1'b0;
  int   ref_ra = 0;

  typedef struct {
    logic [63:0] d;
    logic aq;
    logic rl;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] f64(input int op, input logic [63:0] o, input logic [63:0] s);
    case (op)
      3: return o + s;
      4: return o ^ s;
      5: return o & s;
      6: return o | s;
      7: return ($signed(s) < $signed(o)) ? s : o;
      8: return ($signed(s) > $signed(o)) ? s : o;
      9: return (s < o) ? s : o;
      10: return (s > o) ? s : o;
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] f32(input int op, input logic [31:0] o, input logic [31:0] s);
    case (op)
      3: return o + s;
      4: return o ^ s;
      5: return o & s;
      6: return o | s;
      7: return ($signed(s) < $signed(o)) ? s : o;
      8: return ($signed(s) > $signed(o)) ? s : o;
      9: return (s < o) ? s : o;
      10: return (s > o) ? s : o;
      default: return s;
    endcase
  endfunction

  // monitor: compares each response with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_data, 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rsp_data == e.d, {e.tag, " data"}, rsp_data, e.d);
        check((rsp_aq == e.aq) && (rsp_rl == e.rl) && (rsp_seqcst == (e.aq && e.rl)),
              "R10 ordering sideband", {61'b0, rsp_seqcst, rsp_aq, rsp_rl},
              {61'b0, e.aq && e.rl, e.aq, e.rl});
      end
    end
  end

  task automatic snoop(input int a);
    snoop_valid = 1'b1;
    snoop_addr  = AW'(a);
    if (ref_rv && ref_ra == a) ref_rv = 1'b0;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic do_op(input int op, input int a, input logic [63:0] src, input logic dw,
                       input logic aq, input logic rl, input string tag, input bit intrude = 1'b0);
    exp_t e;
    int lat;
    int n;
    logic [63:0] old;
    bit is_amo;
    old = ref_mem[a];
    is_amo = (op >= 2 && op <= 10);
    if (op == 0) begin
      e.d = dw ? old : sx32(old[31:0]);
      ref_rv = 1'b1; ref_ra = a; lat = 3;
    end else if (op == 1) begin
      if (ref_rv && ref_ra == a) begin
        if (dw) ref_mem[a] = src; else ref_mem[a][31:0] = src[31:0];
        e.d = 64'd0; lat = 2;
      end else begin
        e.d = 64'd1; lat = 1;
      end
      ref_rv = 1'b0;
    end else if (is_amo) begin
      e.d = dw ? old : sx32(old[31:0]);
      ref_mem[a] = dw ? f64(op, old, src) : {old[63:32], f32(op, old[31:0], src[31:0])};
      lat = 4;
    end else begin
      e.d = 64'd0; lat = 1;
    end
    e.aq = aq; e.rl = rl; e.tag = tag;
    q.push_back(e);

    req_valid = 1'b1; req_op = 4'(op); req_addr = AW'(a); req_data = src;
    req_dw = dw; req_aq = aq; req_rl = rl;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_done && n < 20) begin
      if (is_amo) check(mem_lock && busy, "R9 lock held during atomic", {62'b0, mem_lock, busy}, 64'h3);
      if (intrude && n == 1) begin
        req_valid = 1'b1; req_op = 4'd2; req_addr = AW'(50); req_data = 64'hDEAD;
        req_dw = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(n == lat, {tag, " latency"}, 64'(n), 64'(lat));
    check(mem[a] == ref_mem[a], {tag, " memory"}, mem[a], ref_mem[a]);
    if (is_amo) check(!mem_lock, "R9 lock released", {63'b0, mem_lock}, 64'h0);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0001_0003_0005_0007);
      ref_mem[i] = mem[i];
    end
    mem[11] = 64'h1111_2222_F000_0001; ref_mem[11] = mem[11];
    mem[30] = 64'hAAAA_BBBB_7FFF_FFFF; ref_mem[30] = mem[30];
    mem[31] = 64'hCCCC_DDDD_8000_0000; ref_mem[31] = mem[31];
    mem[32] = 64'h5555_6666_FFFF_FFF0; ref_mem[32] = mem[32];
    mem[33] = 64'h7777_8888_0000_0010; ref_mem[33] = mem[33];
    mem[34] = 64'h9999_AAAA_8000_0005; ref_mem[34] = mem[34];
    mem[35] = 64'h1234_0000_FFFF_0000; ref_mem[35] = mem[35];
    mem[24] = 64'hFFFF_FFFF_FFFF_FFFE; ref_mem[24] = mem[24];

    repeat (3) @(negedge clk);
    check(!rsp_done && !busy && !mem_rd && !mem_wr && !mem_lock, "R1 in reset",
          {59'b0, rsp_done, busy, mem_rd, mem_wr, mem_lock}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_done && !busy && !mem_rd && !mem_wr && !mem_lock, "R1 after reset",
          {59'b0, rsp_done, busy, mem_rd, mem_wr, mem_lock}, 64'h0);

    // R2 load-reserved, both widths
    do_op(0, 10, 64'h0, 1'b1, 1'b0, 1'b0, "R2 LR dword");
    do_op(0, 11, 64'h0, 1'b0, 1'b1, 1'b0, "R2 LR word sign-extend");
    // R3 success then R5 repeat fails
    do_op(1, 11, 64'hFEED_FACE_0BAD_F00D, 1'b1, 1'b0, 1'b1, "R3 SC dword success");
    do_op(1, 11, 64'h0123, 1'b1, 1'b0, 1'b0, "R5 SC after SC fails");
    do_op(0, 12, 64'h0, 1'b0, 1'b1, 1'b1, "R2 LR word");
    do_op(1, 12, 64'hAAAA_BBBB_1234_5678, 1'b0, 1'b1, 1'b1, "R3 SC word low lane only");
    // R4 failures
    do_op(1, 13, 64'h77, 1'b1, 1'b0, 1'b0, "R4 SC without reservation");
    do_op(0, 14, 64'h0, 1'b1, 1'b0, 1'b0, "R2 LR");
    do_op(1, 15, 64'h88, 1'b1, 1'b0, 1'b0, "R4 SC other address");
    do_op(1, 14, 64'h99, 1'b1, 1'b0, 1'b0, "R5 SC after failed SC");
    // R6 snoops
    do_op(0, 16, 64'h0, 1'b1, 1'b0, 1'b0, "R2 LR");
    snoop(16);
    do_op(1, 16, 64'h1616, 1'b1, 1'b0, 1'b0, "R6 SC after matching snoop");
    do_op(0, 17, 64'h0, 1'b1, 1'b0, 1'b0, "R2 LR");
    snoop(18);
    do_op(1, 17, 64'h1717, 1'b1, 1'b0, 1'b0, "R6 SC after unrelated snoop");
    // R7 doubleword atomics
    do_op(2, 20, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, 1'b0, "R7 swap");
    do_op(3, 21, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, "R7 add");
    do_op(4, 22, 64'hF0F0_F0F0_F0F0_F0F0, 1'b1, 1'b0, 1'b1, "R7 xor");
    do_op(5, 23, 64'h00FF_00FF_00FF_00FF, 1'b1, 1'b1, 1'b1, "R7 and");
    do_op(6, 25, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b0, "R7 or");
    do_op(7, 24, 64'h0000_0000_0000_0005, 1'b1, 1'b0, 1'b0, "R7 signed min");
    do_op(8, 26, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0, "R7 signed max");
    do_op(9, 24, 64'h0000_0000_0000_0005, 1'b1, 1'b0, 1'b0, "R7 unsigned min");
    do_op(10, 27, 64'hFFFF_0000_0000_0000, 1'b1, 1'b0, 1'b0, "R7 unsigned max");
    // R8 word atomics
    do_op(3, 30, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0, "R8 word add wraps");
    do_op(7, 31, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0, "R8 word signed min");
    do_op(8, 32, 64'h0000_0000_0000_0003, 1'b0, 1'b0, 1'b0, "R8 word signed max");
    do_op(9, 33, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, "R8 word unsigned min");
    do_op(10, 34, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0, 1'b0, "R8 word unsigned max");
    do_op(2, 35, 64'hABCD_EF01_8765_4321, 1'b0, 1'b1, 1'b1, "R8 word swap");
    // R9 request during atomic is ignored
    do_op(3, 40, 64'h10, 1'b1, 1'b0, 1'b0, "R9 add with intruder", 1'b1);
    check(mem[50] == ref_mem[50], "R9 intruder had no effect", mem[50], ref_mem[50]);
    // R12 unused codes
    do_op(11, 41, 64'h55, 1'b1, 1'b1, 1'b0, "R12 code 11");
    do_op(15, 42, 64'h66, 1'b0, 1'b0, 1'b1, "R12 code 15");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R11 all responses received", 64'(q.size()), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule